// File: doc/BRIEF.md
# Audio Zero-Run Detect and Soft Mute Controller

This block sits on the path from a stereo sample stream to a downstream modulator. It watches the serial data line on every bit-clock tick. When that line has held zero for a long, exactly counted run, and detection is enabled, it declares a silent input. It scales each sample by a ramping gain so that muting fades the signal rather than cutting it. It also decides when the output must be held at mid-scale, meaning a signed zero, with the modulator cut off from the output stage.

Three controls can force mid-scale, and they have a fixed priority. The active-low reset beats everything else and also blocks sample input. The operation-enable bit forces mid-scale whatever the data is. The zero-run detector forces mid-scale only while its enable bit is high. With detection disabled, a silent input passes through as ordinary zero samples and the modulator stays connected.

Top module: `audio_zero_mute`

## Requirements
- R1: A run counter advances on each cycle with `bck_tick`=1 and `sdata_bit`=0. A tick with `sdata_bit`=1 restarts it at zero. After ZERO_RUN-1 zero ticks followed by a one bit, no zero condition is declared.
- R2: The zero condition holds from the cycle after the ZERO_RUN-th consecutive zero tick (65536 by default). It does not hold after ZERO_RUN-1 zero ticks. Cycles with `bck_tick`=0 neither advance the run nor break it.
- R3: While `ctl_izd_en`=1 and the zero condition holds, every accepted sample is output as 0 and `mod_connected` is 0.
- R4: While `ctl_izd_en`=0, `mod_connected` stays 1 through any zero run, and samples are output scaled as usual.
- R5: While `ctl_ope`=1, every accepted sample is output as 0 and `mod_connected` is 0, whatever the input data.
- R6: While `rst_n`=0, `out_valid`, `out_left`, `out_right` and `mod_connected` are all 0 and no sample is accepted. This overrides every other control. After reset the gain is full scale, 2^GAIN_BITS.
- R7: While `ctl_mute`=1, the gain falls by one step on each cycle with `smp_valid`=1, down to 0. The output is the floor of (sample × gain) / 2^GAIN_BITS, computed with the gain value from before that cycle's step.
- R8: While `ctl_mute`=0, the gain rises by one step on each valid cycle, up to 2^GAIN_BITS. At that value the output equals the input.
- R9: The run counter saturates at ZERO_RUN. The forced state ends in the cycle after the first tick with `sdata_bit`=1.
- R10: `out_valid` is `smp_valid` delayed by one clock. The output samples update only on valid cycles and otherwise hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; forces mid-scale and blocks input |
| bck_tick | input | 1 | One-cycle strobe marking a bit-clock period |
| sdata_bit | input | 1 | Serial data bit sampled on `bck_tick` for zero detection |
| smp_valid | input | 1 | Strobe qualifying `smp_left` and `smp_right` |
| smp_left | input | SAMPLE_W | Left sample, two's complement |
| smp_right | input | SAMPLE_W | Right sample, two's complement |
| ctl_mute | input | 1 | Soft mute request |
| ctl_ope | input | 1 | Force mid-scale regardless of data |
| ctl_izd_en | input | 1 | Enable forcing on a detected zero run |
| out_valid | output | 1 | Output sample strobe |
| out_left | output | SAMPLE_W | Processed left sample |
| out_right | output | SAMPLE_W | Processed right sample |
| mod_connected | output | 1 | 1 when the modulator drives the output stage |

## Verification
The bench feeds one run that is one tick short of the threshold and then breaks it with a single one bit. A design that counted too far, or did not restart the run, would disconnect there. The second run reaches the threshold exactly. It includes idle cycles with random data on the serial line, which catches a counter that advances on non-tick cycles or is cleared by them. The mute ramp is driven all the way to zero and back to full scale. An off-by-one in the gain limits, or applying the new gain instead of the old one, would show as a wrong sample value. Reset is asserted while the operation-enable, mute and detect bits are all set. Detection is switched off during a saturated run, and the output must reconnect at once.

// File: rtl/azm_pkg.sv
package azm_pkg;

   typedef enum logic [1:0] {
      RAMP_HOLD = 2'd0,
      RAMP_DOWN = 2'd1,
      RAMP_UP   = 2'd2
   } ramp_dir_e;

   function automatic ramp_dir_e ramp_pick(input logic mute_req,
                                           input logic at_floor,
                                           input logic at_top);
      if (mute_req) return at_floor ? RAMP_HOLD : RAMP_DOWN;
      return at_top ? RAMP_HOLD : RAMP_UP;
   endfunction

endpackage

// File: rtl/azm_zero_run.sv
module azm_zero_run #(
   parameter int unsigned RUN_LEN = 65536
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic bit_in,
   output logic zero_det
);
   localparam int unsigned CW = $clog2(RUN_LEN + 1);
   localparam logic [CW-1:0] LIMIT = CW'(RUN_LEN);

   generate
      if (RUN_LEN < 1) begin : g_bad_len
         $error("azm_zero_run: RUN_LEN must be at least 1");
      end
   endgenerate

   logic [CW-1:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= '0;
      end else if (tick) begin
         if (bit_in)              run_q <= '0;
         else if (run_q != LIMIT) run_q <= run_q + 1'b1;
      end
   end

   assign zero_det = (run_q == LIMIT);

endmodule

// File: rtl/azm_gain_ramp.sv
module azm_gain_ramp
   import azm_pkg::*;
#(
   parameter int unsigned GAIN_BITS = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 step,
   input  logic                 mute_req,
   output logic [GAIN_BITS:0]   gain
);
   localparam int unsigned GW = GAIN_BITS + 1;
   localparam logic [GW-1:0] FULL = GW'(1) << GAIN_BITS;

   generate
      if (GAIN_BITS < 1 || GAIN_BITS > 16) begin : g_bad_gain
         $error("azm_gain_ramp: GAIN_BITS must lie in 1..16");
      end
   endgenerate

   logic [GW-1:0] gain_q;
   ramp_dir_e     dir;

   always_comb dir = ramp_pick(mute_req, gain_q == '0, gain_q == FULL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gain_q <= FULL;
      end else if (step) begin
         unique case (dir)
            RAMP_DOWN: gain_q <= gain_q - 1'b1;
            RAMP_UP:   gain_q <= gain_q + 1'b1;
            default:   gain_q <= gain_q;
         endcase
      end
   end

   assign gain = gain_q;

endmodule

// File: rtl/azm_scaler.sv
module azm_scaler #(
   parameter int unsigned SAMPLE_W  = 24,
   parameter int unsigned GAIN_BITS = 8,
   parameter bit          ROUND_PRODUCT = 1'b0
) (
   input  logic signed [SAMPLE_W-1:0] din,
   input  logic        [GAIN_BITS:0]  gain,
   input  logic                       force_mid,
   output logic signed [SAMPLE_W-1:0] dout
);
   localparam int unsigned PW = SAMPLE_W + GAIN_BITS + 2;

   generate
      if (SAMPLE_W < 2) begin : g_bad_w
         $error("azm_scaler: SAMPLE_W must be at least 2");
      end
   endgenerate

   logic signed [PW-1:0] prod;
   logic signed [PW-1:0] adj;

   assign prod = $signed(din) * $signed({1'b0, gain});

   generate
      if (ROUND_PRODUCT) begin : g_round
         assign adj = prod + (PW'(1) <<< (GAIN_BITS - 1));
      end else begin : g_floor
         assign adj = prod;
      end
   endgenerate

   assign dout = force_mid ? '0 : SAMPLE_W'(adj >>> GAIN_BITS);

endmodule

// File: rtl/audio_zero_mute.sv
module audio_zero_mute #(
   parameter int unsigned SAMPLE_W      = 24,
   parameter int unsigned GAIN_BITS     = 8,
   parameter int unsigned ZERO_RUN      = 65536,
   parameter bit          ROUND_PRODUCT = 1'b0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       bck_tick,
   input  logic                       sdata_bit,
   input  logic                       smp_valid,
   input  logic signed [SAMPLE_W-1:0] smp_left,
   input  logic signed [SAMPLE_W-1:0] smp_right,
   input  logic                       ctl_mute,
   input  logic                       ctl_ope,
   input  logic                       ctl_izd_en,
   output logic                       out_valid,
   output logic signed [SAMPLE_W-1:0] out_left,
   output logic signed [SAMPLE_W-1:0] out_right,
   output logic                       mod_connected
);
   localparam int unsigned NUM_CH = 2;

   logic               zero_det;
   logic               force_mid;
   logic [GAIN_BITS:0] gain_q;

   logic signed [SAMPLE_W-1:0] ch_in     [NUM_CH];
   logic signed [SAMPLE_W-1:0] ch_scaled [NUM_CH];
   logic signed [SAMPLE_W-1:0] ch_q      [NUM_CH];

   azm_zero_run #(.RUN_LEN(ZERO_RUN)) u_run (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (bck_tick),
      .bit_in   (sdata_bit),
      .zero_det (zero_det)
   );

   azm_gain_ramp #(.GAIN_BITS(GAIN_BITS)) u_ramp (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (smp_valid),
      .mute_req (ctl_mute),
      .gain     (gain_q)
   );

   // operation-enable wins over the detector; reset is handled by the flops
   assign force_mid     = ctl_ope | (ctl_izd_en & zero_det);
   assign mod_connected = rst_n & ~force_mid;

   assign ch_in[0] = smp_left;
   assign ch_in[1] = smp_right;

   genvar ch;
   generate
      for (ch = 0; ch < NUM_CH; ch++) begin : g_ch
         azm_scaler #(
            .SAMPLE_W      (SAMPLE_W),
            .GAIN_BITS     (GAIN_BITS),
            .ROUND_PRODUCT (ROUND_PRODUCT)
         ) u_scale (
            .din       (ch_in[ch]),
            .gain      (gain_q),
            .force_mid (force_mid),
            .dout      (ch_scaled[ch])
         );

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         ch_q[ch] <= '0;
            else if (smp_valid) ch_q[ch] <= ch_scaled[ch];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_valid <= 1'b0;
      else        out_valid <= smp_valid;
   end

   assign out_left  = ch_q[0];
   assign out_right = ch_q[1];

endmodule

// File: rtl/audio_zero_mute_chk.sv
module audio_zero_mute_chk #(
   parameter int unsigned SAMPLE_W  = 24,
   parameter int unsigned GAIN_BITS = 8
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       bck_tick,
   input logic                       sdata_bit,
   input logic                       smp_valid,
   input logic                       ctl_ope,
   input logic                       ctl_izd_en,
   input logic                       zero_det,
   input logic [GAIN_BITS:0]         gain_q,
   input logic                       out_valid,
   input logic signed [SAMPLE_W-1:0] out_left,
   input logic signed [SAMPLE_W-1:0] out_right,
   input logic                       mod_connected
);
   localparam logic [GAIN_BITS:0] FULL = (GAIN_BITS+1)'(1) << GAIN_BITS;

   always_comb begin
      if (!rst_n) begin
         AST_RESET_QUIET: assert (!out_valid && !mod_connected && out_left == '0 && out_right == '0); // R6
      end
   end

   AST_OPE_FORCES: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ctl_ope) && $past(smp_valid)) |-> (out_left == '0 && out_right == '0)); // R5

   AST_IZD_DISCONNECT: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_izd_en && zero_det) |-> !mod_connected); // R3

   AST_ZERO_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(zero_det) |-> ($past(bck_tick) && !$past(sdata_bit))); // R2

   AST_ONE_BIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (bck_tick && sdata_bit) |=> !zero_det); // R9

   AST_GAIN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      gain_q <= FULL); // R7

   AST_GAIN_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (gain_q == $past(gain_q)) || (gain_q == $past(gain_q) + 1'b1) || ($past(gain_q) == gain_q + 1'b1)); // R8

   AST_HOLD_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(smp_valid) |-> ($stable(out_left) && $stable(out_right))); // R10

endmodule

bind audio_zero_mute audio_zero_mute_chk #(
   .SAMPLE_W  (SAMPLE_W),
   .GAIN_BITS (GAIN_BITS)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .bck_tick      (bck_tick),
   .sdata_bit     (sdata_bit),
   .smp_valid     (smp_valid),
   .ctl_ope       (ctl_ope),
   .ctl_izd_en    (ctl_izd_en),
   .zero_det      (zero_det),
   .gain_q        (gain_q),
   .out_valid     (out_valid),
   .out_left      (out_left),
   .out_right     (out_right),
   .mod_connected (mod_connected)
);

// File: tb/audio_zero_mute_bench.sv
module audio_zero_mute_bench;
   localparam int SW    = 24;
   localparam int GB    = 8;
   localparam int ZR    = 65536;
   localparam int FULLG = 1 << GB;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bck_tick = 1'b0, sdata_bit = 1'b0, smp_valid = 1'b0;
   logic signed [SW-1:0] smp_left = '0, smp_right = '0;
   logic ctl_mute = 1'b0, ctl_ope = 1'b0, ctl_izd_en = 1'b0;
   logic out_valid, mod_connected;
   logic signed [SW-1:0] out_left, out_right;

   always #4 clk = ~clk;

   audio_zero_mute u_audio_zero_mute (
      .clk(clk), .rst_n(rst_n), .bck_tick(bck_tick), .sdata_bit(sdata_bit),
      .smp_valid(smp_valid), .smp_left(smp_left), .smp_right(smp_right),
      .ctl_mute(ctl_mute), .ctl_ope(ctl_ope), .ctl_izd_en(ctl_izd_en),
      .out_valid(out_valid), .out_left(out_left), .out_right(out_right),
      .mod_connected(mod_connected)
   );

   int    n_chk = 0, n_fail = 0, wd = 0;
   string cur_req = "R6 reset state";

   // behavioural reference state
   int     m_run = 0;
   int     m_gain = FULLG;
   bit     m_ov = 0;
   longint m_l = 0, m_r = 0;

   function automatic longint scale(longint s, int g);
      longint p;
      p = s * longint'(g);
      return p >>> GB;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_run = 0; m_gain = FULLG; m_ov = 0; m_l = 0; m_r = 0;
      end else begin
         bit frc;
         frc = ctl_ope || (ctl_izd_en && m_run == ZR);
         m_ov = smp_valid;
         if (smp_valid) begin
            m_l = frc ? 0 : scale(longint'(smp_left), m_gain);
            m_r = frc ? 0 : scale(longint'(smp_right), m_gain);
            if (ctl_mute) begin if (m_gain > 0) m_gain--; end
            else begin if (m_gain < FULLG) m_gain++; end
         end
         if (bck_tick) m_run = sdata_bit ? 0 : ((m_run < ZR) ? m_run + 1 : m_run);
      end
   end

   task automatic check1(string what, longint act, longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", cur_req, what, act, exp);
      end
   endtask

   task automatic compare();
      @(negedge clk);
      check1("out_valid", longint'(out_valid), longint'(m_ov));
      check1("out_left", longint'(out_left), m_l);
      check1("out_right", longint'(out_right), m_r);
      check1("mod_connected", longint'(mod_connected),
             longint'(rst_n && !(ctl_ope || (ctl_izd_en && m_run == ZR))));
   endtask

   function automatic bit pick(int mode);
      return (mode == 2) ? bit'($urandom_range(0, 1)) : bit'(mode);
   endfunction

   task automatic run(int n, int tk_mode, int bit_mode, int v_mode);
      for (int i = 0; i < n; i++) begin
         compare();
         bck_tick  = pick(tk_mode);
         sdata_bit = pick(bit_mode);
         smp_valid = pick(v_mode);
         smp_left  = SW'($urandom);
         smp_right = SW'($urandom);
      end
   endtask

   task automatic finish_up();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   always @(posedge clk) begin
      wd++;
      if (wd > 190000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog %s actual=%0d expected<=190000", cur_req, wd);
         finish_up();
      end
   end

   initial begin
      cur_req = "R6 reset state";
      run(5, 2, 2, 2);
      rst_n = 1'b1;

      cur_req = "R10 R4 plain stream";
      run(200, 2, 2, 2);

      cur_req = "R5 operation enable";
      ctl_ope = 1'b1; run(60, 2, 2, 2);
      ctl_ope = 1'b0; run(5, 2, 2, 2);

      cur_req = "R7 mute ramp down";
      ctl_mute = 1'b1; run(300, 2, 2, 1);
      check1("muted left", longint'(out_left), 0);

      cur_req = "R8 mute release";
      ctl_mute = 1'b0; run(300, 2, 2, 1);

      cur_req = "R1 run broken one short";
      ctl_izd_en = 1'b1;
      run(ZR - 1, 1, 0, 2);
      run(1, 1, 1, 2);
      check1("R1 still connected", longint'(mod_connected), 1);

      cur_req = "R2 exact threshold";
      run(ZR - 1, 1, 0, 2);
      run(30, 0, 2, 2);
      run(1, 1, 0, 2);
      run(2, 1, 0, 2);
      check1("R2 disconnected", longint'(mod_connected), 0);

      cur_req = "R3 forced mid-scale";
      run(200, 1, 0, 1);

      cur_req = "R4 detect disabled";
      ctl_izd_en = 1'b0; run(50, 1, 0, 2);
      ctl_izd_en = 1'b1; run(20, 1, 0, 2);

      cur_req = "R9 release on one bit";
      run(1, 1, 1, 2);
      run(60, 2, 2, 2);

      cur_req = "R6 reset priority";
      ctl_ope = 1'b1; ctl_mute = 1'b1;
      run(20, 2, 2, 2);
      rst_n = 1'b0; run(10, 2, 2, 2);
      ctl_ope = 1'b0; ctl_mute = 1'b0;
      rst_n = 1'b1; run(40, 2, 2, 2);

      finish_up();
   end

endmodule